// File: doc/BRIEF.md
# Control endpoint OUT-data packet buffer

This block holds one OUT data-stage packet of a control endpoint between the serial interface engine and firmware. The engine pushes packet bytes through a byte-wide write strobe and then closes the packet with a pulse: `pkt_good` for a packet that arrived intact, `pkt_bad` for one that did not. A good close publishes the number of stored bytes on `rx_count`, raises the sticky `rx_done` flag and locks the buffer. A bad close throws the partial packet away. Setup packets never reach this buffer.

While the buffer is locked, `rx_ready` is low so that the engine can refuse the host, and anything the engine offers is dropped. Firmware drains the packet one byte per `rd_en` pulse from the combinational `rd_data` port. It then pulses `rd_done` to reopen the buffer. `rx_done` is cleared separately by `rx_done_clr`. A `buf_clear` pulse flushes everything except the flag.

When more than one control input arrives in the same cycle, one of them wins, in this order:
1. `buf_clear`
2. `rd_done`
3. `pkt_good`
4. `pkt_bad`
5. `wr_en`

The lower-ranked inputs in that cycle are ignored.

Top module: `ctl_out_pktbuf`

## Requirements
- R1: After reset, `rx_ready` is 1, `rx_done` is 0, `rx_count` is 0 and `rd_data` is 0.
- R2: A `pkt_good` pulse while `rx_ready` is 1 has these effects from the next cycle: `rx_count` equals the number of bytes stored since the buffer was last emptied, `rx_done` is 1 and `rx_ready` is 0.
- R3: While `rx_ready` is 0, `wr_en`, `pkt_good` and `pkt_bad` have no effect on the stored bytes, on `rx_count` or on `rx_done`.
- R4: While locked, `rd_data` shows the stored bytes in arrival order, starting with the first byte. Each `rd_en` pulse advances to the next byte in the following cycle.
- R5: `rd_data` is 0 whenever no unread byte remains, and also whenever the buffer is not locked. An `rd_en` pulse in that situation does not move the read position.
- R6: An `rd_done` pulse has these effects from the next cycle: `rx_ready` is 1, both positions rewind to the start, and `rx_count` and `rx_done` are unchanged.
- R7: A `pkt_bad` pulse while ready discards the bytes of the current packet, so the next byte is stored first. `rx_count` and `rx_done` are unchanged, and `rx_ready` stays 1.
- R8: An `rx_done_clr` pulse clears `rx_done` in the next cycle. If a packet is accepted in the same cycle, the flag is set instead.
- R9: The buffer holds 16 bytes. Bytes written beyond the sixteenth are dropped, so `rx_count` never exceeds 16.
- R10: A `buf_clear` pulse has these effects from the next cycle: the buffer is empty and unlocked, `rx_count` is 0 and `rd_data` is 0. It leaves `rx_done` unchanged and overrides every other input in the same cycle.
- R11: A `wr_en` in the same cycle as `pkt_good`, `pkt_bad`, `rd_done` or `buf_clear` stores nothing. A packet closed with no bytes reports a count of 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe from the serial engine |
| wr_data | input | 8 | Byte to store |
| pkt_good | input | 1 | Packet ended without error |
| pkt_bad | input | 1 | Packet ended with an error |
| rd_en | input | 1 | Firmware consumes the byte on rd_data |
| rd_data | output | 8 | Current unread byte, or 0 when none is available |
| rd_done | input | 1 | Firmware has finished reading; reopen the buffer |
| buf_clear | input | 1 | Flush the buffer |
| rx_done_clr | input | 1 | Clear the receive-complete flag |
| rx_count | output | 5 | Byte count of the last accepted packet |
| rx_done | output | 1 | Receive-complete flag |
| rx_ready | output | 1 | Buffer can accept packet bytes |

## Verification
Some rules are checked on every cycle by the assertions:
- the lock holds `rx_count` steady;
- an accepted packet sets the flag and drops `rx_ready`;
- `rd_done` and `buf_clear` reopen the buffer;
- the count never passes the capacity;
- an unlocked buffer always shows zero on `rd_data`.

Other behaviour depends on byte values and ordering, so only the bench scenarios can show it:
- the bytes come out in arrival order;
- a bad packet rewinds so that its successor lands in the first slot;
- overflow bytes are dropped;
- a write that loses to a same-cycle packet end leaves no trace.

// File: rtl/pktbuf_pkg.sv
package pktbuf_pkg;

    // Winning control event for one cycle, in priority order of decode.
    typedef enum logic [2:0] {
        EV_NONE    = 3'd0,
        EV_CLEAR   = 3'd1,
        EV_RELEASE = 3'd2,
        EV_ACCEPT  = 3'd3,
        EV_DROP    = 3'd4,
        EV_BYTE    = 3'd5
    } pktbuf_ev_e;

endpackage

// File: rtl/pktbuf_evsel.sv
module pktbuf_evsel
    import pktbuf_pkg::*;
(
    input  logic       clear_i,
    input  logic       release_i,
    input  logic       good_i,
    input  logic       bad_i,
    input  logic       wr_i,
    input  logic       locked_i,
    output pktbuf_ev_e ev_o
);

    always_comb begin
        if (clear_i)        ev_o = EV_CLEAR;
        else if (release_i) ev_o = EV_RELEASE;
        else if (locked_i)  ev_o = EV_NONE;
        else if (good_i)    ev_o = EV_ACCEPT;
        else if (bad_i)     ev_o = EV_DROP;
        else if (wr_i)      ev_o = EV_BYTE;
        else                ev_o = EV_NONE;
    end

endmodule

// File: rtl/pktbuf_store.sv
module pktbuf_store #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic          clk,
    input  logic          we_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);

    logic [DW-1:0] slots [DEPTH];

    // Storage carries no reset; the read side is gated by the controller.
    always_ff @(posedge clk) begin
        if (we_i) slots[waddr_i] <= wdata_i;
    end

    assign rdata_o = slots[raddr_i];

endmodule

// File: rtl/pktbuf_ctrl.sv
module pktbuf_ctrl
    import pktbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  pktbuf_ev_e    ev_i,
    input  logic          rd_en_i,
    input  logic          flag_clr_i,
    output logic          locked_o,
    output logic          flag_o,
    output logic [CW-1:0] count_o,
    output logic          we_o,
    output logic [AW-1:0] waddr_o,
    output logic [AW-1:0] raddr_o,
    output logic          rd_valid_o
);

    localparam logic [CW-1:0] CAP = CW'(DEPTH);

    typedef struct packed {
        logic [CW-1:0] wptr;
        logic [CW-1:0] rptr;
        logic [CW-1:0] cnt;
        logic          locked;
        logic          flag;
    } ctrl_t;

    ctrl_t st_d, st_q;
    logic  has_room;
    logic  unread;

    assign has_room = (st_q.wptr < CAP);
    assign unread   = st_q.locked && (st_q.rptr < st_q.cnt);

    always_comb begin
        st_d = st_q;
        unique case (ev_i)
            EV_CLEAR: begin
                st_d.wptr   = '0;
                st_d.rptr   = '0;
                st_d.cnt    = '0;
                st_d.locked = 1'b0;
            end
            EV_RELEASE: begin
                st_d.wptr   = '0;
                st_d.rptr   = '0;
                st_d.locked = 1'b0;
            end
            EV_ACCEPT: begin
                st_d.cnt    = st_q.wptr;
                st_d.rptr   = '0;
                st_d.locked = 1'b1;
            end
            EV_DROP: begin
                st_d.wptr = '0;
            end
            EV_BYTE: begin
                if (has_room) st_d.wptr = st_q.wptr + 1'b1;
            end
            default: ;
        endcase

        if (rd_en_i && unread && (ev_i != EV_CLEAR) && (ev_i != EV_RELEASE))
            st_d.rptr = st_q.rptr + 1'b1;

        if (flag_clr_i)          st_d.flag = 1'b0;
        if (ev_i == EV_ACCEPT)   st_d.flag = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign locked_o   = st_q.locked;
    assign flag_o     = st_q.flag;
    assign count_o    = st_q.cnt;
    assign we_o       = (ev_i == EV_BYTE) && has_room;
    assign waddr_o    = st_q.wptr[AW-1:0];
    assign raddr_o    = st_q.rptr[AW-1:0];
    assign rd_valid_o = unread;

endmodule

// File: rtl/ctl_out_pktbuf.sv
module ctl_out_pktbuf
    import pktbuf_pkg::*;
#(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int AW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    input  logic          pkt_good,
    input  logic          pkt_bad,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    input  logic          rd_done,
    input  logic          buf_clear,
    input  logic          rx_done_clr,
    output logic [CW-1:0] rx_count,
    output logic          rx_done,
    output logic          rx_ready
);

    pktbuf_ev_e    ev;
    logic          locked;
    logic          we;
    logic [AW-1:0] waddr;
    logic [AW-1:0] raddr;
    logic          rd_valid;
    logic [DW-1:0] slot_q;

    pktbuf_evsel u_evsel (
        .clear_i   (buf_clear),
        .release_i (rd_done),
        .good_i    (pkt_good),
        .bad_i     (pkt_bad),
        .wr_i      (wr_en),
        .locked_i  (locked),
        .ev_o      (ev)
    );

    pktbuf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_i       (ev),
        .rd_en_i    (rd_en),
        .flag_clr_i (rx_done_clr),
        .locked_o   (locked),
        .flag_o     (rx_done),
        .count_o    (rx_count),
        .we_o       (we),
        .waddr_o    (waddr),
        .raddr_o    (raddr),
        .rd_valid_o (rd_valid)
    );

    pktbuf_store #(.DEPTH(DEPTH), .DW(DW)) u_store (
        .clk     (clk),
        .we_i    (we),
        .waddr_i (waddr),
        .wdata_i (wr_data),
        .raddr_i (raddr),
        .rdata_o (slot_q)
    );

    assign rd_data  = rd_valid ? slot_q : '0;
    assign rx_ready = ~locked;

endmodule

// File: rtl/ctl_out_pktbuf_chk.sv
module ctl_out_pktbuf_chk #(
    parameter int DEPTH = 16,
    parameter int DW    = 8,
    localparam int CW   = $clog2(DEPTH + 1)
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [DW-1:0] wr_data,
    input logic          pkt_good,
    input logic          pkt_bad,
    input logic          rd_en,
    input logic [DW-1:0] rd_data,
    input logic          rd_done,
    input logic          buf_clear,
    input logic          rx_done_clr,
    input logic [CW-1:0] rx_count,
    input logic          rx_done,
    input logic          rx_ready
);

    logic accept;
    assign accept = rx_ready && pkt_good && !buf_clear && !rd_done;

    // R2: an accepted packet raises the flag and locks
    a_r2_accept_locks: assert property (@(posedge clk) disable iff (!rst_n)
        accept |=> (rx_done && !rx_ready));

    // R3: count frozen while locked unless reopened or flushed
    a_r3_locked_count_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_ready && !buf_clear && !rd_done) |=> $stable(rx_count));

    // R5: nothing readable when unlocked
    a_r5_unlocked_zero: assert property (@(posedge clk) disable iff (!rst_n)
        rx_ready |-> (rd_data == '0));

    // R6: read-done reopens with count and flag kept
    a_r6_release_reopens: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_done && !buf_clear && !rx_done_clr) |=> (rx_ready && $stable(rx_count) && $stable(rx_done)));

    // R7: bad end keeps count and flag
    a_r7_bad_keeps_status: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_ready && pkt_bad && !pkt_good && !buf_clear && !rd_done && !rx_done_clr)
        |=> ($stable(rx_count) && $stable(rx_done) && rx_ready));

    // R8: flag clear without a same-cycle acceptance
    a_r8_flag_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done_clr && !accept) |=> !rx_done);

    // R9: count bounded by capacity
    a_r9_count_cap: assert property (@(posedge clk) disable iff (!rst_n)
        rx_count <= CW'(DEPTH));

    // R10: flush empties and unlocks
    a_r10_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        buf_clear |=> (rx_ready && rx_count == '0 && rd_data == '0));

endmodule

bind ctl_out_pktbuf ctl_out_pktbuf_chk #(.DEPTH(DEPTH), .DW(DW)) u_chk (.*);

// File: tb/ctl_out_pktbuf_tb.sv
module ctl_out_pktbuf_tb;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH      = 16;

    logic       clk = 1'b0;
    logic       rst_n;
    logic       wr_en, pkt_good, pkt_bad, rd_en, rd_done, buf_clear, rx_done_clr;
    logic [7:0] wr_data;
    logic [7:0] rd_data;
    logic [4:0] rx_count;
    logic       rx_done, rx_ready;

    int total = 0;
    int bad   = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ctl_out_pktbuf u_dut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data),
        .pkt_good(pkt_good), .pkt_bad(pkt_bad), .rd_en(rd_en), .rd_data(rd_data),
        .rd_done(rd_done), .buf_clear(buf_clear), .rx_done_clr(rx_done_clr),
        .rx_count(rx_count), .rx_done(rx_done), .rx_ready(rx_ready)
    );

    typedef struct packed {
        logic       wr;
        logic [7:0] wd;
        logic       good;
        logic       bd;
        logic       rd;
        logic       done;
        logic       clr;
        logic       dclr;
        logic       e_ready;
        logic       e_done;
        logic [4:0] e_cnt;
        logic [7:0] e_rd;
    } vec_t;

    localparam int NV = 24;
    localparam vec_t VECS [NV] = '{
        '{1'b1, 8'hA1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 8'h00}, // R4 store
        '{1'b1, 8'hB2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 8'h00},
        '{1'b1, 8'hC3, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 8'hA1}, // R2 accept
        '{1'b1, 8'h55, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 8'hA1}, // R3 write locked
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 8'hA1}, // R3 good locked
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 8'hA1}, // R3 bad locked
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 8'hB2}, // R4 read order
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 8'hC3},
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 8'h00}, // R5 exhausted
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd3, 8'h00}, // R5 extra read
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 5'd3, 8'h00}, // R8 clear flag
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3, 8'h00}, // R6 release
        '{1'b1, 8'h11, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3, 8'h00},
        '{1'b1, 8'h22, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3, 8'h00},
        '{1'b0, 8'h00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3, 8'h00}, // R7 bad end
        '{1'b1, 8'h77, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 5'd3, 8'h00},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd1, 8'h77}, // R7 rewound
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 5'd0, 8'h00}, // R10 flush
        '{1'b1, 8'h99, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b1, 5'd0, 8'h00},
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 5'd1, 8'h99}, // R8 set wins
        '{1'b1, 8'h44, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd1, 8'h00}, // R11 write loses to release
        '{1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 5'd0, 8'h00}, // R11 empty packet
        '{1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 5'd0, 8'h00}  // R6 release
    };

    task automatic chk(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic drive(input logic wr, input logic [7:0] wd, input logic good,
                         input logic bd, input logic rd, input logic done,
                         input logic clr, input logic dclr);
        wr_en = wr; wr_data = wd; pkt_good = good; pkt_bad = bd;
        rd_en = rd; rd_done = done; buf_clear = clr; rx_done_clr = dclr;
        @(negedge clk);
    endtask

    task automatic idle();
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic summary();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            summary();
        end
    end

    initial begin
        rst_n = 1'b0;
        wr_en = 0; wr_data = 0; pkt_good = 0; pkt_bad = 0;
        rd_en = 0; rd_done = 0; buf_clear = 0; rx_done_clr = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1 ready", int'(rx_ready), 1);
        chk("R1 done", int'(rx_done), 0);
        chk("R1 count", int'(rx_count), 0);
        chk("R1 rd_data", int'(rd_data), 0);
        rst_n = 1'b1;
        @(negedge clk);

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i].wr, VECS[i].wd, VECS[i].good, VECS[i].bd,
                  VECS[i].rd, VECS[i].done, VECS[i].clr, VECS[i].dclr);
            chk($sformatf("vec%0d ready", i), int'(rx_ready), int'(VECS[i].e_ready));
            chk($sformatf("vec%0d done", i),  int'(rx_done),  int'(VECS[i].e_done));
            chk($sformatf("vec%0d count", i), int'(rx_count), int'(VECS[i].e_cnt));
            chk($sformatf("vec%0d rd_data", i), int'(rd_data), int'(VECS[i].e_rd));
        end

        // R9 overflow: 20 bytes offered, 16 kept
        for (int k = 0; k < 20; k++) drive(1'b1, 8'(k + 1), 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R9 count capped", int'(rx_count), DEPTH);
        for (int k = 0; k < DEPTH - 1; k++) drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R9 last kept byte", int'(rd_data), DEPTH);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0);
        chk("R5 after last byte", int'(rd_data), 0);
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0);

        // R11 byte in the same cycle as packet end is not stored
        drive(1'b1, 8'h05, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 8'h06, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R11 count", int'(rx_count), 1);
        chk("R11 first byte", int'(rd_data), 8'h05);

        // R10 flush while locked, then mid-packet
        drive(1'b0, 8'h00, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10 unlocked", int'(rx_ready), 1);
        drive(1'b1, 8'hE1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 8'hE2, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b1, 8'hE3, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0); // clear beats good
        chk("R10 clear beats good", int'(rx_ready), 1);
        drive(1'b1, 8'h3C, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        drive(1'b0, 8'h00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0);
        chk("R10 count after flush", int'(rx_count), 1);
        chk("R10 first byte after flush", int'(rd_data), 8'h3C);
        idle();

        finished = 1;
        summary();
    end

endmodule